// File: doc/BRIEF.md
# CRT Timing Controller

This block is a programmable raster timing core for a character-based text display. A host loads a small bank of byte-wide registers through a two-port scheme. It first writes a register index to the index port. It then reads or writes the selected register through the data port. Host address bit `a0_i` picks the port: 0 is the index port and 1 is the data port. All eighteen registers read back exactly as written, so software can verify its own setup.

From the programmed values, the core runs three nested counters: a character counter within a scanline, a scanline counter within a character row, and a row counter within a frame. From these it drives horizontal sync, vertical sync and display enable. It also produces a linear character-memory address that steps once per character, so downstream logic can fetch character codes in order. It reports the scanline within the current row, and it raises a cursor flag that blink control can gate. The core produces no pixel data.

Top module: `crt_timing_ctrl`

## Requirements
- R1: A write (`cs_i`=1, `we_i`=1) with `a0_i`=0 latches `wdata_i[4:0]` as the register index; upper bits are dropped, so 0x24 selects index 4. A write with `a0_i`=1 stores `wdata_i` into the register at the latched index.
- R2: Indices 18 to 31 are unused: data-port writes to them change no register, and data-port reads from them return 0.
- R3: Every register 0..17 returns all 8 stored bits on a data-port read (`cs_i`=1, `we_i`=0, `a0_i`=1). `rdata_o` is 0 for index-port reads and whenever no read is in progress.
- R4: The character counter runs from 0 and wraps to 0 once it reaches or passes register 0. The scanline counter advances at each wrap and wraps once it reaches or passes register 9 bits [4:0]. The row counter advances at each scanline wrap and wraps once it reaches or passes register 4 bits [6:0]. `ra_o` is the scanline count. `de_o` is high while the character count is below register 1 and the row count is below register 6 bits [6:0].
- R5: `hsync_o` is high while the character count is at least register 2 and below register 2 plus the width in register 3 bits [3:0]. A width of 0 means 16.
- R6: `vsync_o` is high while the row count equals register 7 bits [6:0] and the scanline count is below register 3 bits [7:4]. A width of 0 means 16.
- R7: `ma_o` is a row base plus the character count, modulo 2^14. The row base grows by register 1 after the last scanline of each row. At the end of a frame it is reloaded with the start address {register 12 bits [5:0], register 13}.
- R8: `cursor_o` is high when `de_o` is high, `ma_o` equals {register 14 bits [5:0], register 15}, the scanline count lies from register 10 bits [4:0] to register 11 bits [4:0] inclusive, and the cursor is in its visible phase.
- R9: Register 10 bits [6:5] select the cursor mode. 0 is always visible and 1 is never visible. 2 is visible and hidden in turn every 16 frames, starting visible after reset. 3 does the same every 32 frames.
- R10: Reset clears all registers, the latched index, the counters, the row base and the frame count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock, one character per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Host access strobe |
| we_i | input | 1 | Host write (1) or read (0) |
| a0_i | input | 1 | Port select: 0 index, 1 data |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| ma_o | output | 14 | Character memory address |
| ra_o | output | 5 | Scanline within character row |
| cursor_o | output | 1 | Cursor match gated by blink |

## Verification
The bench keeps the default blink dividers of 16 and 32 frames. It programs a tiny raster of ten characters, two scanlines and four rows, so one frame lasts 80 cycles. Both blink periods therefore complete many times within a few thousand cycles. Exact cursor-hit totals over whole blink periods check each mode. A later change to the line length and a zero sync width cover the wrap and the width-16 rule.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 18;
  localparam int IDX_W    = 5;
  localparam int MA_W     = 14;
  localparam int ROW_W    = 7;
  localparam int RA_W     = 5;
  localparam int SW_W     = 4;

  // register indices
  localparam int IX_HTOT   = 0;
  localparam int IX_HDISP  = 1;
  localparam int IX_HSPOS  = 2;
  localparam int IX_SWID   = 3;
  localparam int IX_VTOT   = 4;
  localparam int IX_VDISP  = 6;
  localparam int IX_VSPOS  = 7;
  localparam int IX_MSCAN  = 9;
  localparam int IX_CSTART = 10;
  localparam int IX_CEND   = 11;
  localparam int IX_SA_HI  = 12;
  localparam int IX_SA_LO  = 13;
  localparam int IX_CA_HI  = 14;
  localparam int IX_CA_LO  = 15;

  typedef enum logic [1:0] {
    CUR_STEADY = 2'd0,
    CUR_HIDDEN = 2'd1,
    CUR_BLINK_FAST = 2'd2,
    CUR_BLINK_SLOW = 2'd3
  } cur_mode_e;

  typedef struct packed {
    logic [REG_W-1:0] h_total;
    logic [REG_W-1:0] h_disp;
    logic [REG_W-1:0] h_sync_pos;
    logic [SW_W-1:0]  h_sync_w;
    logic [SW_W-1:0]  v_sync_w;
    logic [ROW_W-1:0] v_total;
    logic [ROW_W-1:0] v_disp;
    logic [ROW_W-1:0] v_sync_pos;
    logic [RA_W-1:0]  max_scan;
    logic [MA_W-1:0]  start_addr;
  } tim_cfg_t;

  typedef struct packed {
    logic [RA_W-1:0] row_first;
    logic [RA_W-1:0] row_last;
    cur_mode_e       mode;
    logic [MA_W-1:0] addr;
  } cur_cfg_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_data_i,
  input  logic             a0_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output tim_cfg_t         tim_o,
  output cur_cfg_t         cur_o
);
  logic [IDX_W-1:0]                idx_q;
  logic [NUM_REGS-1:0][REG_W-1:0]  regs_q;
  logic [NUM_REGS-1:0]             hit;
  logic                            idx_valid;
  logic                            wr_data;

  assign idx_valid = idx_q < IDX_W'(NUM_REGS);
  assign wr_data   = wr_i && a0_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = wr_data && (idx_q == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (wr_i && !a0_i) begin
      idx_q <= wdata_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hit[i]) regs_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_data_i && idx_q == IDX_W'(i)) rdata_o = regs_q[i];
    end
  end

  always_comb begin
    tim_o.h_total    = regs_q[IX_HTOT];
    tim_o.h_disp     = regs_q[IX_HDISP];
    tim_o.h_sync_pos = regs_q[IX_HSPOS];
    tim_o.h_sync_w   = regs_q[IX_SWID][SW_W-1:0];
    tim_o.v_sync_w   = regs_q[IX_SWID][REG_W-1:SW_W];
    tim_o.v_total    = regs_q[IX_VTOT][ROW_W-1:0];
    tim_o.v_disp     = regs_q[IX_VDISP][ROW_W-1:0];
    tim_o.v_sync_pos = regs_q[IX_VSPOS][ROW_W-1:0];
    tim_o.max_scan   = regs_q[IX_MSCAN][RA_W-1:0];
    tim_o.start_addr = {regs_q[IX_SA_HI][MA_W-REG_W-1:0], regs_q[IX_SA_LO]};
    cur_o.row_first  = regs_q[IX_CSTART][RA_W-1:0];
    cur_o.row_last   = regs_q[IX_CEND][RA_W-1:0];
    cur_o.mode       = cur_mode_e'(regs_q[IX_CSTART][RA_W+1:RA_W]);
    cur_o.addr       = {regs_q[IX_CA_HI][MA_W-REG_W-1:0], regs_q[IX_CA_LO]};
  end

  // R2: out-of-range data writes leave the bank untouched
  p_ignore_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !idx_valid) |=> $stable(regs_q));

  // R1: an index write is visible on the next cycle
  p_index_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a0_i) |=> idx_q == $past(wdata_i[IDX_W-1:0]));
endmodule

// File: rtl/crtc_scan.sv
module crtc_scan
  import crtc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  tim_cfg_t        cfg_i,
  output logic [MA_W-1:0] ma_o,
  output logic [RA_W-1:0] ra_o,
  output logic            de_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            frame_end_o
);
  logic [REG_W-1:0] hc_q;
  logic [RA_W-1:0]  ra_q;
  logic [ROW_W-1:0] vc_q;
  logic [MA_W-1:0]  base_q;
  logic             line_end, row_end;
  logic [SW_W:0]    hsw_eff, vsw_eff;

  assign line_end    = hc_q >= cfg_i.h_total;
  assign row_end     = line_end && (ra_q >= cfg_i.max_scan);
  assign frame_end_o = row_end && (vc_q >= cfg_i.v_total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      ra_q   <= '0;
      vc_q   <= '0;
      base_q <= '0;
    end else begin
      hc_q <= line_end ? '0 : hc_q + 8'd1;
      if (line_end) ra_q <= row_end ? '0 : ra_q + 5'd1;
      if (row_end) begin
        vc_q   <= frame_end_o ? '0 : vc_q + 7'd1;
        base_q <= frame_end_o ? cfg_i.start_addr : base_q + MA_W'(cfg_i.h_disp);
      end
    end
  end

  // zero width field means the longest pulse
  assign hsw_eff = (cfg_i.h_sync_w == '0) ? 5'd16 : {1'b0, cfg_i.h_sync_w};
  assign vsw_eff = (cfg_i.v_sync_w == '0) ? 5'd16 : {1'b0, cfg_i.v_sync_w};

  assign ma_o    = base_q + MA_W'(hc_q);
  assign ra_o    = ra_q;
  assign de_o    = (hc_q < cfg_i.h_disp) && (vc_q < cfg_i.v_disp);
  assign hsync_o = (hc_q >= cfg_i.h_sync_pos) &&
                   ({1'b0, hc_q} < ({1'b0, cfg_i.h_sync_pos} + 9'(hsw_eff)));
  assign vsync_o = (vc_q == cfg_i.v_sync_pos) && (ra_q < vsw_eff);

  p_hc_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end |=> hc_q == '0);

  p_ma_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end |=> ma_o == $past(ma_o) + MA_W'(1));

  p_frame_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> ma_o == $past(cfg_i.start_addr));
endmodule

// File: rtl/crtc_cursor.sv
module crtc_cursor
  import crtc_pkg::*;
#(
  parameter int FAST_LOG2 = 4,
  parameter int SLOW_LOG2 = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cur_cfg_t        cfg_i,
  input  logic            frame_end_i,
  input  logic            de_i,
  input  logic [MA_W-1:0] ma_i,
  input  logic [RA_W-1:0] ra_i,
  output logic            cursor_o
);
  localparam int FRM_W = SLOW_LOG2 + 1;

  logic [FRM_W-1:0] frm_q;
  logic             visible, row_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          frm_q <= '0;
    else if (frame_end_i) frm_q <= frm_q + FRM_W'(1);
  end

  always_comb begin
    unique case (cfg_i.mode)
      CUR_STEADY:     visible = 1'b1;
      CUR_HIDDEN:     visible = 1'b0;
      CUR_BLINK_FAST: visible = !frm_q[FAST_LOG2];
      default:        visible = !frm_q[SLOW_LOG2];
    endcase
  end

  assign row_hit  = (ra_i >= cfg_i.row_first) && (ra_i <= cfg_i.row_last);
  assign cursor_o = de_i && visible && row_hit && (ma_i == cfg_i.addr);

  p_cursor_in_de_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cursor_o |-> de_i);

  p_hidden_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == CUR_HIDDEN) |-> !cursor_o);

  p_frame_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> frm_q == $past(frm_q) + FRM_W'(1));
endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crtc_pkg::*;
#(
  parameter int CUR_FAST_LOG2 = 4,
  parameter int CUR_SLOW_LOG2 = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic        a0_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic [13:0] ma_o,
  output logic [4:0]  ra_o,
  output logic        cursor_o
);
  tim_cfg_t tim;
  cur_cfg_t cur;
  logic     frame_end;
  logic     wr, rd_data;

  assign wr      = cs_i && we_i;
  assign rd_data = cs_i && !we_i && a0_i;

  crtc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .rd_data_i (rd_data),
    .a0_i      (a0_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .tim_o     (tim),
    .cur_o     (cur)
  );

  crtc_scan u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (tim),
    .ma_o        (ma_o),
    .ra_o        (ra_o),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .frame_end_o (frame_end)
  );

  crtc_cursor #(
    .FAST_LOG2 (CUR_FAST_LOG2),
    .SLOW_LOG2 (CUR_SLOW_LOG2)
  ) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cur),
    .frame_end_i (frame_end),
    .de_i        (de_o),
    .ma_i        (ma_o),
    .ra_i        (ra_o),
    .cursor_o    (cursor_o)
  );
endmodule

// File: tb/crt_timing_ctrl_tb.sv
module crt_timing_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0, a0 = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hsync, vsync, de, cursor;
  logic [13:0] ma;
  logic [4:0]  ra;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .a0_i(a0),
    .wdata_i(wdata), .rdata_o(rdata), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .ma_o(ma), .ra_o(ra), .cursor_o(cursor)
  );

  localparam logic [7:0] CFG [18] = '{
    8'h09, 8'h06, 8'h07, 8'h12, 8'h03, 8'hA5, 8'h02, 8'h03, 8'h5A,
    8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h08, 8'h3C, 8'hC3};

  // {we, a0, data, expected read}
  localparam logic [17:0] VEC [16] = '{
    {1'b1, 1'b0, 8'h00, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h09},
    {1'b1, 1'b0, 8'h03, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h12},
    {1'b1, 1'b0, 8'h05, 8'h00}, {1'b0, 1'b1, 8'h00, 8'hA5},
    {1'b1, 1'b0, 8'h0F, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h08},
    {1'b1, 1'b0, 8'h11, 8'h00}, {1'b0, 1'b1, 8'h00, 8'hC3},
    {1'b1, 1'b0, 8'h24, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h03},
    {1'b1, 1'b0, 8'h14, 8'h00}, {1'b1, 1'b1, 8'h77, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h00}, {1'b0, 1'b0, 8'h00, 8'h00}};

  // reference raster built from the requirements
  logic [7:0] m_reg [18];
  logic [4:0] m_idx;
  int m_hc, m_ra, m_vc, m_base, m_frm;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit le, re, fe;
    if (!rst_n) begin
      for (int i = 0; i < 18; i++) m_reg[i] <= 8'h00;
      m_idx <= '0; m_hc <= 0; m_ra <= 0; m_vc <= 0; m_base <= 0; m_frm <= 0;
    end else begin
      le = m_hc >= int'(m_reg[0]);
      re = le && (m_ra >= int'(m_reg[9] & 8'h1F));
      fe = re && (m_vc >= int'(m_reg[4] & 8'h7F));
      m_hc <= le ? 0 : m_hc + 1;
      if (le) m_ra <= re ? 0 : m_ra + 1;
      if (re) begin
        m_vc   <= fe ? 0 : m_vc + 1;
        m_base <= fe ? ((int'(m_reg[12] & 8'h3F) << 8) | int'(m_reg[13]))
                     : (m_base + int'(m_reg[1])) & 16'h3FFF;
      end
      if (fe) m_frm <= m_frm + 1;
      if (cs && we && !a0) m_idx <= wdata[4:0];
      if (cs && we && a0 && m_idx < 5'd18) m_reg[m_idx] <= wdata;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_scan();
    int hsw, vsw, ema, eca, mode;
    bit ede, ehs, evs, vis, ecur;
    hsw  = ((m_reg[3] & 8'h0F) == 0) ? 16 : int'(m_reg[3] & 8'h0F);
    vsw  = ((m_reg[3] >> 4) == 0) ? 16 : int'(m_reg[3] >> 4);
    ema  = (m_base + m_hc) & 16'h3FFF;
    ede  = (m_hc < int'(m_reg[1])) && (m_vc < int'(m_reg[6] & 8'h7F));
    ehs  = (m_hc >= int'(m_reg[2])) && (m_hc < int'(m_reg[2]) + hsw);
    evs  = (m_vc == int'(m_reg[7] & 8'h7F)) && (m_ra < vsw);
    mode = int'((m_reg[10] >> 5) & 8'h03);
    vis  = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 :
           (mode == 2) ? (((m_frm >> 4) & 1) == 0) : (((m_frm >> 5) & 1) == 0);
    eca  = (int'(m_reg[14] & 8'h3F) << 8) | int'(m_reg[15]);
    ecur = ede && vis && (ema == eca) && (m_ra >= int'(m_reg[10] & 8'h1F)) &&
           (m_ra <= int'(m_reg[11] & 8'h1F));
    chk("R4 ra", int'(ra), m_ra);
    chk("R4 de", int'(de), int'(ede));
    chk("R5 hsync", int'(hsync), int'(ehs));
    chk("R6 vsync", int'(vsync), int'(evs));
    chk("R7 ma", int'(ma), ema);
    chk("R8 R9 cursor", int'(cursor), int'(ecur));
  endtask

  task automatic run(int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      check_scan();
      if (cursor) hits++;
    end
  endtask

  task automatic bus(bit w, bit sel, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = w; a0 = sel; wdata = d;
    #(CLK_PERIOD/4);
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 1'b0; we = 1'b0; a0 = 1'b0; wdata = '0;
  endtask

  task automatic wr_reg(int idx, logic [7:0] v);
    bus(1'b1, 1'b0, 8'(idx));
    bus(1'b1, 1'b1, v);
  endtask

  task automatic readback_all(string req, bit zero);
    for (int i = 0; i < 18; i++) begin
      bus(1'b1, 1'b0, 8'(i));
      bus(1'b0, 1'b1, 8'h00);
      chk(req, int'(rdata), zero ? 0 : int'(CFG[i]));
    end
    idle();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rdata", int'(rdata), 0);
    chk("R10 de", int'(de), 0);
    chk("R10 ma", int'(ma), 0);
    chk("R10 cursor", int'(cursor), 0);
    readback_all("R10 regs", 1'b1);

    for (int i = 0; i < 18; i++) wr_reg(i, CFG[i]);
    idle();
    // R1 R2 R3 vector table
    for (int k = 0; k < 16; k++) begin
      bus(VEC[k][17], VEC[k][16], VEC[k][15:8]);
      if (!VEC[k][17]) chk("R1 R2 R3 table", int'(rdata), int'(VEC[k][7:0]));
    end
    idle();
    chk("R3 idle rdata", int'(rdata), 0);
    readback_all("R2 R3 bank", 1'b0);

    run(200, hits);
    run(800, hits);
    chk("R8 steady hits", hits, 20);

    wr_reg(10, 8'h01); idle();
    run(100, hits);
    run(800, hits);
    chk("R8 row range hits", hits, 10);

    wr_reg(11, 8'h00); idle();
    run(100, hits);
    run(800, hits);
    chk("R8 empty range hits", hits, 0);

    wr_reg(11, 8'h01); wr_reg(10, 8'h20); idle();
    run(100, hits);
    run(800, hits);
    chk("R9 hidden hits", hits, 0);

    wr_reg(10, 8'h40); idle();
    run(100, hits);
    run(2560, hits);
    chk("R9 fast blink hits", hits, 32);

    wr_reg(10, 8'h60); idle();
    run(100, hits);
    run(5120, hits);
    chk("R9 slow blink hits", hits, 64);

    // new line length, zero sync widths
    wr_reg(10, 8'h00); wr_reg(0, 8'h0B); wr_reg(3, 8'h00); idle();
    run(400, hits);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    readback_all("R10 re-reset", 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule